// File: doc/BRIEF.md
# Memory-to-Link DMA Read Engine

This block copies a programmed number of fixed-size chunks from local memory to host memory across a packet link. The host sets a source address, a destination address and a chunk count, then writes a start bit. All four writes arrive as incoming posted writes. For each chunk the engine sends one read request to the memory controller and collects the returned beats in a small buffer. It then pushes an outbound posted-write packet into the transmit posted queue. Each packet is a command word, a destination address word and the chunk's data words, all passing through one multiplexer.

The host learns how far the engine has got by sending status reads on the non-posted channel. Each status read gets exactly one tagged response word. The engine stalls cleanly while the transmit queue reports full. A chunk is 4 words of 32 bits, so both addresses advance by 16 bytes per chunk.

Top module: `dma_rd_engine`

## Requirements
- R1: Posted writes select a register by `rxp_addr_i`: 0 source address, 1 destination address, 2 chunk count. Writing 3 with data bit 0 set is a start request. These registers take effect only on the next accepted start.
- R2: After a start with a nonzero count, `mem_req_o` rises with `mem_addr_o` equal to the source address. Both hold until `mem_gnt_i`. Exactly one request is made per chunk, and the address of chunk c is source + 16·c.
- R3: After the 4th `mem_rvalid_i` beat of a chunk, the first word pushed is the command word. Bits 5:0 hold 0x2C (posted write), bits 9:6 hold 3 (data words minus one), and all other bits are zero. The command word for 4 data words is therefore 0x000000EC.
- R4: The second word pushed is the destination address of the chunk with bits 1:0 cleared, where chunk c targets destination + 16·c. The 4 data words follow in the order they were returned.
- R5: The sequence repeats until the programmed count of chunks is done. This makes exactly 6·count pushes in total, in chunk order.
- R6: A word is pushed only when `txp_wr_o` is high, and `txp_wr_o` is never high while `txp_full_i` is high. A stall holds the current selection, so no word is lost or duplicated.
- R7: A status word has bit 0 = busy and bit 1 = done, with all other bits zero. Done rises in the cycle after the last data word is accepted, and busy falls in that same cycle. Done is cleared by the next accepted start.
- R8: A start request that arrives while busy is ignored. The running transfer is not restarted or lengthened.
- R9: Each `rxnp_valid_i` cycle produces exactly one `rsp_valid_o` cycle on the following clock. That response carries the same tag and the status value from the request cycle. No response appears without a request.
- R10: A start with a count of zero sets done (busy stays low) on the next clock and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxp_valid_i | input | 1 | Incoming posted register write |
| rxp_addr_i | input | 2 | Register select |
| rxp_data_i | input | 32 | Register write data |
| rxnp_valid_i | input | 1 | Incoming status read |
| rxnp_tag_i | input | 5 | Tag of the status read |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_tag_o | output | 5 | Response tag |
| rsp_data_o | output | 32 | Response data (status) |
| mem_req_o | output | 1 | Memory chunk read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Returned data beat valid |
| mem_rdata_i | input | 32 | Returned data beat |
| txp_full_i | input | 1 | Transmit posted queue full |
| txp_wr_o | output | 1 | Push a word into the transmit posted queue |
| txp_data_o | output | 32 | Word pushed |

## Verification
A status read can land in the same cycle that the queue accepts the final data word of a transfer. When that happens, the read and the completion update compete for the status value. The bench watches the transmit port, and the moment the last data word is being written with full low, it issues a status read in that very cycle. That response must show busy=1 and done=0. A read one cycle later must show busy=0 and done=1. The bench also sweeps counts, full patterns and grant delays, and compares every pushed word with values computed from the programmed addresses.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FILL, ST_EMIT} dma_state_e;
  localparam logic [5:0] CMD_POSTED_WR = 6'h2C;
  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_LEN  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;
endpackage

// File: rtl/dma_rd_regs.sv
module dma_rd_regs
  import dma_rd_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxp_valid_i,
  input  logic [1:0]    rxp_addr_i,
  input  logic [DW-1:0] rxp_data_i,
  input  logic          rxnp_valid_i,
  input  logic [TW-1:0] rxnp_tag_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output logic          start_o,
  output logic          rsp_valid_o,
  output logic [TW-1:0] rsp_tag_o,
  output logic [DW-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      len_o <= '0;
    end else if (rxp_valid_i) begin
      case (rxp_addr_i)
        REG_SRC: src_o <= rxp_data_i;
        REG_DST: dst_o <= rxp_data_i;
        REG_LEN: len_o <= rxp_data_i[LW-1:0];
        default: ;
      endcase
    end
  end

  // start while busy is dropped here
  assign start_o = rxp_valid_i && (rxp_addr_i == REG_CTRL) && rxp_data_i[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rxnp_valid_i;
      if (rxnp_valid_i) begin
        rsp_tag_o  <= rxnp_tag_i;
        rsp_data_o <= {{(DW-2){1'b0}}, done_i, busy_i};
      end
    end
  end

  AST_RSP_PER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxnp_valid_i |=> rsp_valid_o && (rsp_tag_o == $past(rxnp_tag_i))); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxnp_valid_i |=> !rsp_valid_o); // R9
endmodule

// File: rtl/dma_rd_txmux.sv
module dma_rd_txmux
  import dma_rd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int SEL_W = $clog2(BEATS + 2)
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DW-1:0]       dst_i,
  input  logic [BEATS*DW-1:0] buf_i,
  output logic [DW-1:0]       data_o
);
  localparam logic [3:0] CNT_M1 = 4'(BEATS - 1);

  logic [DW-1:0] cmd_w;
  assign cmd_w = {{(DW-10){1'b0}}, CNT_M1, CMD_POSTED_WR};

  always_comb begin
    data_o = cmd_w;
    if (sel_i == SEL_W'(1)) data_o = {dst_i[DW-1:2], 2'b00};
    for (int k = 0; k < BEATS; k++) begin
      if (sel_i == SEL_W'(k + 2)) data_o = buf_i[k*DW +: DW];
    end
  end
endmodule

// File: rtl/dma_rd_fsm.sv
module dma_rd_fsm
  import dma_rd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int BEATS = 4,
  localparam int SEL_W  = $clog2(BEATS + 2),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DW-1:0]       src_i,
  input  logic [DW-1:0]       dst_i,
  input  logic [LW-1:0]       len_i,
  output logic                mem_req_o,
  output logic [DW-1:0]       mem_addr_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [DW-1:0]       mem_rdata_i,
  input  logic                txp_full_i,
  output logic                txp_wr_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [DW-1:0]       dst_o,
  output logic [BEATS*DW-1:0] buf_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int CHUNK_BYTES = BEATS * DW / 8;
  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(BEATS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  dma_state_e        state_q;
  logic [DW-1:0]     cur_src_q, cur_dst_q;
  logic [LW-1:0]     remain_q;
  logic [BEAT_W-1:0] beat_q;
  logic [SEL_W-1:0]  sel_q;
  logic              done_q;
  logic [DW-1:0]     buf_q [BEATS];

  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = cur_src_q;
  assign txp_wr_o   = (state_q == ST_EMIT) && !txp_full_i;
  assign sel_o      = sel_q;
  assign dst_o      = cur_dst_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[g] <= '0;
      else if (state_q == ST_FILL && mem_rvalid_i && beat_q == BEAT_W'(g)) buf_q[g] <= mem_rdata_i;
    end
    assign buf_o[g*DW +: DW] = buf_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_src_q <= '0;
      cur_dst_q <= '0;
      remain_q  <= '0;
      beat_q    <= '0;
      sel_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          cur_src_q <= src_i;
          cur_dst_q <= dst_i;
          remain_q  <= len_i;
          done_q    <= (len_i == '0);
          if (len_i != '0) state_q <= ST_REQ;
        end
        ST_REQ: if (mem_gnt_i) begin
          beat_q  <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (mem_rvalid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            sel_q   <= '0;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: if (!txp_full_i) begin
          if (sel_q == LAST_SEL) begin
            sel_q     <= '0;
            remain_q  <= remain_q - 1'b1;
            cur_src_q <= cur_src_q + DW'(CHUNK_BYTES);
            cur_dst_q <= cur_dst_q + DW'(CHUNK_BYTES);
            if (remain_q == LW'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end else begin
            sel_q <= sel_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o))); // R2
  AST_STALL_HOLDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMIT && txp_full_i) |=> (state_q == ST_EMIT && $stable(sel_q))); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txp_wr_o && sel_q == LAST_SEL && remain_q == LW'(1)) |=> (done_o && !busy_o)); // R7
  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i == '0) |=> (done_o && !mem_req_o && !busy_o)); // R10
endmodule

// File: rtl/dma_rd_engine.sv
module dma_rd_engine
  import dma_rd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int BEATS = 4,
  parameter int TW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxp_valid_i,
  input  logic [1:0]    rxp_addr_i,
  input  logic [DW-1:0] rxp_data_i,
  input  logic          rxnp_valid_i,
  input  logic [TW-1:0] rxnp_tag_i,
  output logic          rsp_valid_o,
  output logic [TW-1:0] rsp_tag_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          txp_full_i,
  output logic          txp_wr_o,
  output logic [DW-1:0] txp_data_o
);
  localparam int SEL_W = $clog2(BEATS + 2);

  logic [DW-1:0]       src_w, dst_w, cur_dst_w;
  logic [LW-1:0]       len_w;
  logic                start_w, busy_w, done_w;
  logic [SEL_W-1:0]    sel_w;
  logic [BEATS*DW-1:0] buf_w;

  dma_rd_regs #(.DW(DW), .LW(LW), .TW(TW)) u_regs (
    .clk_i, .rst_ni, .rxp_valid_i, .rxp_addr_i, .rxp_data_i,
    .rxnp_valid_i, .rxnp_tag_i, .busy_i(busy_w), .done_i(done_w),
    .src_o(src_w), .dst_o(dst_w), .len_o(len_w), .start_o(start_w),
    .rsp_valid_o, .rsp_tag_o, .rsp_data_o
  );

  dma_rd_fsm #(.DW(DW), .LW(LW), .BEATS(BEATS)) u_fsm (
    .clk_i, .rst_ni, .start_i(start_w), .src_i(src_w), .dst_i(dst_w), .len_i(len_w),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .txp_full_i, .txp_wr_o, .sel_o(sel_w), .dst_o(cur_dst_w), .buf_o(buf_w),
    .busy_o(busy_w), .done_o(done_w)
  );

  dma_rd_txmux #(.DW(DW), .BEATS(BEATS)) u_mux (
    .sel_i(sel_w), .dst_i(cur_dst_w), .buf_i(buf_w), .data_o(txp_data_o)
  );
endmodule

// File: tb/dma_rd_engine_tb_top.sv
`timescale 1ns/1ps
module dma_rd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        rxp_valid = 0, rxnp_valid = 0, mem_gnt = 0, mem_rvalid = 0, txp_full = 0;
  logic [1:0]  rxp_addr = 0;
  logic [31:0] rxp_data = 0, mem_rdata = 0;
  logic [4:0]  rxnp_tag = 0;
  logic        rsp_valid, mem_req, txp_wr;
  logic [4:0]  rsp_tag;
  logic [31:0] rsp_data, mem_addr, txp_data;

  dma_rd_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rxp_valid_i(rxp_valid), .rxp_addr_i(rxp_addr), .rxp_data_i(rxp_data),
    .rxnp_valid_i(rxnp_valid), .rxnp_tag_i(rxnp_tag),
    .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .txp_full_i(txp_full), .txp_wr_o(txp_wr), .txp_data_o(txp_data)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a, input int b);
    return (a + 32'(4 * b)) ^ 32'h5A5A_0000;
  endfunction

  // environment: memory, queue sink, probe
  logic [31:0] cap [64];
  logic [31:0] rqa [16];
  int cap_n = 0, rq_n = 0, ret_cnt = 0, ret_beat = 0, wait_cnt = 0;
  int gnt_delay = 0, full_mode = 0, cyc = 0;
  logic [31:0] ret_addr = 0;
  bit probe_armed = 0;
  int probe_at = 0, probe_stage = 0;

  always @(negedge clk) begin
    cyc++;
    if (probe_stage == 1) begin
      rxnp_valid = 1'b1; rxnp_tag = 5'd8;
      chk(rsp_valid && rsp_tag == 5'd7, "R9 probe tag", {27'd0, rsp_tag}, 32'd7);
      chk(rsp_data == 32'h1, "R7 read with last word", rsp_data, 32'h1);
      probe_stage = 2;
    end else if (probe_stage == 2) begin
      rxnp_valid = 1'b0;
      chk(rsp_valid && rsp_tag == 5'd8, "R9 probe tag 2", {27'd0, rsp_tag}, 32'd8);
      chk(rsp_data == 32'h2, "R7 read after last word", rsp_data, 32'h2);
      probe_stage = 3;
    end
    mem_gnt = 1'b0;
    if (ret_cnt > 0) begin
      mem_rvalid = 1'b1;
      mem_rdata = pat(ret_addr, ret_beat);
      ret_beat++; ret_cnt--;
    end else begin
      mem_rvalid = 1'b0;
      if (mem_req) begin
        if (wait_cnt >= gnt_delay) begin
          mem_gnt = 1'b1; ret_addr = mem_addr; ret_cnt = 4; ret_beat = 0; wait_cnt = 0;
          if (rq_n < 16) rqa[rq_n] = mem_addr;
          rq_n++;
        end else wait_cnt++;
      end
    end
    case (full_mode)
      1: txp_full = cyc[0];
      2: txp_full = (cyc % 5) < 3;
      default: txp_full = 1'b0;
    endcase
    #1;
    if (txp_wr && txp_full) chk(0, "R6 write while full", 32'd1, 32'd0);
    if (txp_wr) begin
      if (probe_armed && cap_n == probe_at) begin
        rxnp_valid = 1'b1; rxnp_tag = 5'd7; probe_armed = 0; probe_stage = 1;
      end
      if (cap_n < 64) cap[cap_n] = txp_data;
      cap_n++;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); rxp_valid = 1'b1; rxp_addr = a; rxp_data = d;
    @(negedge clk); rxp_valid = 1'b0;
  endtask

  int tag_ctr = 0;
  task automatic rd_status(output logic [31:0] d);
    logic [4:0] t;
    tag_ctr++;
    t = 5'(tag_ctr);
    @(negedge clk); rxnp_valid = 1'b1; rxnp_tag = t;
    @(negedge clk); rxnp_valid = 1'b0;
    chk(rsp_valid && rsp_tag == t, "R9 response tag", {27'd0, rsp_tag}, {27'd0, t});
    d = rsp_data;
  endtask

  task automatic check_stream(input int len, input logic [31:0] src, input logic [31:0] dst);
    chk(cap_n == 6 * len, "R5 word count", 32'(cap_n), 32'(6 * len));
    chk(rq_n == len, "R2 request count", 32'(rq_n), 32'(len));
    for (int c = 0; c < len && c < 10; c++) begin
      chk(rqa[c] == src + 32'(16 * c), "R2 request address", rqa[c], src + 32'(16 * c));
      chk(cap[6*c] == 32'h0000_00EC, "R3 command word", cap[6*c], 32'h0000_00EC);
      chk(cap[6*c+1] == ((dst + 32'(16 * c)) & ~32'h3), "R4 address word",
          cap[6*c+1], (dst + 32'(16 * c)) & ~32'h3);
      for (int b = 0; b < 4; b++)
        chk(cap[6*c+2+b] == pat(src + 32'(16 * c), b), "R4 data word",
            cap[6*c+2+b], pat(src + 32'(16 * c), b));
    end
  endtask

  task automatic run_case(input int len, input logic [31:0] src, input logic [31:0] dst,
                          input int fm, input int gd);
    logic [31:0] s;
    cap_n = 0; rq_n = 0; full_mode = fm; gnt_delay = gd;
    wr_reg(2'd0, src); wr_reg(2'd1, dst); wr_reg(2'd2, 32'(len)); // R1
    wr_reg(2'd3, 32'h1);
    s = 0;
    for (int i = 0; i < 400; i++) begin
      rd_status(s);
      if (s[1]) break;
    end
    chk(s == 32'h2, "R7 final status", s, 32'h2);
    check_stream(len, src, dst);
  endtask

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!txp_wr && !mem_req && !rsp_valid, "R7 reset outputs", {29'd0, txp_wr, mem_req, rsp_valid}, 32'd0);
    rd_status(s);
    chk(s == 32'h0, "R7 reset status", s, 32'h0);
    @(negedge clk);
    chk(!rsp_valid, "R9 single response", {31'd0, rsp_valid}, 32'd0);

    // sweep: counts x full patterns x grant delays
    for (int len = 1; len <= 3; len++)
      for (int fm = 0; fm < 3; fm++)
        for (int gd = 0; gd < 2; gd++)
          run_case(len, 32'h0001_0000 + 32'(len * 32'h100) + 32'(fm * 32'h40),
                   32'h8000_0004 + 32'(gd * 32'h1000) + 32'(len * 32'h20), fm, gd);

    // R10 zero count
    rq_n = 0; cap_n = 0;
    wr_reg(2'd2, 32'd0); wr_reg(2'd3, 32'h1);
    rd_status(s);
    chk(s == 32'h2, "R10 zero count status", s, 32'h2);
    repeat (10) @(negedge clk);
    chk(rq_n == 0 && cap_n == 0, "R10 no memory request", 32'(rq_n + cap_n), 32'd0);

    // R7 start clears done; R8 start while busy ignored
    cap_n = 0; rq_n = 0; full_mode = 2; gnt_delay = 1;
    wr_reg(2'd0, 32'h0002_0000); wr_reg(2'd1, 32'h9000_0000); wr_reg(2'd2, 32'd2);
    wr_reg(2'd3, 32'h1);
    rd_status(s);
    chk(s == 32'h1, "R7 done cleared by start", s, 32'h1);
    wr_reg(2'd0, 32'h0003_0000); wr_reg(2'd2, 32'd3);
    wr_reg(2'd3, 32'h1); // R8
    for (int i = 0; i < 400; i++) begin
      rd_status(s);
      if (s[1]) break;
    end
    check_stream(2, 32'h0002_0000, 32'h9000_0000); // R8 original transfer only

    // status read in the cycle the last word is accepted
    cap_n = 0; rq_n = 0; full_mode = 1; gnt_delay = 0;
    wr_reg(2'd0, 32'h0004_0000); wr_reg(2'd1, 32'hA000_0010); wr_reg(2'd2, 32'd2);
    probe_at = 11; probe_armed = 1;
    wr_reg(2'd3, 32'h1);
    for (int i = 0; i < 400 && probe_stage != 3; i++) @(negedge clk);
    chk(probe_stage == 3, "R7 probe reached", 32'(probe_stage), 32'd3);
    check_stream(2, 32'h0004_0000, 32'hA000_0010);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R5 actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule